// File: doc/BRIEF.md
# Dual Interval Timer with Merged Interrupt

This block places two independent down-counting interval timers behind one 4 KB register window. A simple word-wide bus with separate read and write strobes reaches the block. The block sends each access to the first or the second timer by its offset. A short run of read-only identification bytes sits at the top of the window, and every other offset reads as zero and ignores writes.

Each timer has its own counting-tick enable input. The surrounding system can therefore clock the two timers at different rates; 1 MHz tick pulses for both is the expected default. A timer decrements once per scaled tick. The scaling is a prescale of 1, 16 or 256 tick pulses. A timer runs free, reloads periodically or stops after a single expiry. Each expiry latches an interrupt flag. The two masked flags are ORed onto one interrupt output.

Top module: `dual_timer`

## Requirements
- R1: Offsets 0x000 to 0x01F reach timer A and offsets 0x020 to 0x03F reach timer B, with 0x020 subtracted. Inside a window the word slots are: +0x00 control, +0x04 immediate load, +0x08 deferred load, +0x0C current count, +0x10 raw flag, +0x14 masked flag, +0x18 flag clear (write only, reads 0) and +0x1C spare (reads 0).
- R2: Offsets 0xFE0, 0xFE4 … 0xFFC read the bytes 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, zero-extended. Writes there change nothing.
- R3: Reads of any other offset return 0. This includes 0xF00, 0xF04, 0x040 and any address with nonzero bits [1:0]. Writes to such offsets change no timer state.
- R4: Read data is registered. bus_rdata shows the addressed value one cycle after bus_rd, taken from the state before that clock edge, and it holds while no read is issued.
- R5: After reset bus_rdata is 0 and irq is low. Each timer's control reads 0x02, its limit reads 0, its count reads 0xFFFFFFFF and its flags read 0.
- R6: The control word has run in bit 0, interrupt enable in bit 1, mode in bits 3:2 (0 free, 1 periodic, 2 or 3 one-shot), wide in bit 4 and prescale in bits 6:5. An immediate load sets both the limit and the count, with the count masked to 16 bits when wide is 0. A deferred load sets only the limit. Writes to the count slot are ignored.
- R7: While run is 1 the count drops by one per scaled tick. Prescale 0 gives one scaled tick per tick pulse, 1 gives one per 16 and 2 or 3 gives one per 256. A control write restarts the prescaler. Tick pulses have no effect while run is 0.
- R8: A scaled tick that finds the count at 0 is an expiry. After an expiry the count becomes the limit in periodic mode, and 0xFFFF or 0xFFFFFFFF (by wide) in free mode. In one-shot mode the count stays at 0 and the run bit clears.
- R9: An expiry sets the raw flag and a write to the clear slot resets it. An expiry in the same cycle as a clear write leaves the flag set.
- R10: The masked flag is the raw flag ANDed with the interrupt enable. irq is high while either timer's masked flag is high.
- R11: tick_a moves only timer A and tick_b moves only timer B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_a | input | 1 | Counting-tick enable for timer A |
| tick_b | input | 1 | Counting-tick enable for timer B |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Merged interrupt |

## Verification
Two events can meet in one cycle: a timer's own expiry, which sets the flag, and a software write to the clear slot. The bench first clears the flag and ticks the count down to zero. It then asserts the tick and the clear write in the same cycle. A later read of the raw flag must return 1, because the expiry wins. A clear issued alone afterwards must return the flag to 0.

// File: rtl/dt_pkg.sv
package dt_pkg;
  localparam int CTRL_W = 7;

  typedef struct packed {
    logic [1:0] ps;
    logic       wide;
    logic [1:0] mode;
    logic       ie;
    logic       run;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{ps: 2'd0, wide: 1'b0, mode: 2'd0, ie: 1'b1, run: 1'b0};

  localparam logic [2:0] SLOT_CTRL   = 3'd0;
  localparam logic [2:0] SLOT_LOADN  = 3'd1;
  localparam logic [2:0] SLOT_LOADL  = 3'd2;
  localparam logic [2:0] SLOT_COUNT  = 3'd3;
  localparam logic [2:0] SLOT_RAW    = 3'd4;
  localparam logic [2:0] SLOT_MASKED = 3'd5;
  localparam logic [2:0] SLOT_CLEAR  = 3'd6;

  localparam logic [1:0] MODE_FREE     = 2'd0;
  localparam logic [1:0] MODE_PERIODIC = 2'd1;

  function automatic logic [7:0] ident_byte(input logic [2:0] k);
    case (k)
      3'd0:    return 8'h04;
      3'd1:    return 8'h18;
      3'd2:    return 8'h14;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/dt_prescale.sv
module dt_prescale #(
  parameter int MID_LOG2  = 4,
  parameter int SLOW_LOG2 = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       tick,
  input  logic [1:0] sel,
  output logic       scaled
);
  localparam int PRE_W = SLOW_LOG2;

  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (tick)  cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    case (sel)
      2'd0:    scaled = tick;
      2'd1:    scaled = tick && (&cnt_q[MID_LOG2-1:0]);
      default: scaled = tick && (&cnt_q);
    endcase
  end
endmodule

// File: rtl/dt_timer.sv
module dt_timer
  import dt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int IDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_val,
  output logic              irq_o,
  output logic              flag_o,
  output logic [DATA_W-1:0] lim_o
);
  localparam logic [DATA_W-1:0] NARROW_MASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] lim_q;
  logic [DATA_W-1:0] cnt_q;
  logic              flag_q;

  logic [DATA_W-1:0] mask;
  logic wr_ctrl, wr_loadn, wr_loadl, wr_clear;
  logic scaled, at_zero, expire, oneshot;

  assign mask     = ctrl_q.wide ? {DATA_W{1'b1}} : NARROW_MASK;
  assign wr_ctrl  = wr_en && (idx == SLOT_CTRL);
  assign wr_loadn = wr_en && (idx == SLOT_LOADN);
  assign wr_loadl = wr_en && (idx == SLOT_LOADL);
  assign wr_clear = wr_en && (idx == SLOT_CLEAR);
  assign oneshot  = ctrl_q.mode[1];

  dt_prescale #(.MID_LOG2(4), .SLOW_LOG2(8)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .clr    (wr_ctrl || !ctrl_q.run),
    .tick   (tick && ctrl_q.run),
    .sel    (ctrl_q.ps),
    .scaled (scaled)
  );

  assign at_zero = ((cnt_q & mask) == '0);
  assign expire  = scaled && at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
    end else if (expire && oneshot) begin
      ctrl_q.run <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                       lim_q <= '0;
    else if (wr_loadn || wr_loadl) lim_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= {DATA_W{1'b1}};
    end else if (wr_loadn) begin
      cnt_q <= wdata & mask;
    end else if (scaled) begin
      if (at_zero) begin
        if (oneshot)                           cnt_q <= '0;
        else if (ctrl_q.mode == MODE_PERIODIC) cnt_q <= lim_q & mask;
        else                                   cnt_q <= mask;
      end else begin
        cnt_q <= (cnt_q - 1'b1) & mask;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           flag_q <= 1'b0;
    else if (expire)   flag_q <= 1'b1;
    else if (wr_clear) flag_q <= 1'b0;
  end

  always_comb begin
    case (idx)
      SLOT_CTRL:              rd_val = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      SLOT_LOADN, SLOT_LOADL: rd_val = lim_q;
      SLOT_COUNT:             rd_val = cnt_q;
      SLOT_RAW:               rd_val = {{(DATA_W-1){1'b0}}, flag_q};
      SLOT_MASKED:            rd_val = {{(DATA_W-1){1'b0}}, flag_q & ctrl_q.ie};
      default:                rd_val = '0;
    endcase
  end

  assign irq_o  = flag_q & ctrl_q.ie;
  assign flag_o = flag_q;
  assign lim_o  = lim_q;

  assert_hold_when_stopped_R7: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.run && !wr_en) |=> $stable(cnt_q));

  assert_expiry_sets_flag_R9: assert property (@(posedge clk) disable iff (rst)
    expire |=> flag_q);

  assert_clear_alone_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_clear && !scaled) |=> !flag_q);

  assert_oneshot_stops_R8: assert property (@(posedge clk) disable iff (rst)
    (expire && oneshot && !wr_ctrl) |=> !ctrl_q.run);

  assert_free_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (expire && ctrl_q.mode == MODE_FREE && !wr_en) |=> (cnt_q == $past(mask)));
endmodule

// File: rtl/dt_id_rom.sv
module dt_id_rom
  import dt_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       byte_o
);
  assign byte_o = ident_byte(idx);
endmodule

// File: rtl/dual_timer.sv
module dual_timer #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int WIN_LOG2 = 5,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_a,
  input  logic              tick_b,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int NUM_TMR = 2;
  localparam int SLOT_W  = ADDR_W - WIN_LOG2;
  localparam int IDX_W   = WIN_LOG2 - 2;
  localparam logic [SLOT_W-1:0] ID_SLOT = {SLOT_W{1'b1}};

  logic [SLOT_W-1:0]  slot;
  logic [IDX_W-1:0]   idx;
  logic               aligned;
  logic [NUM_TMR-1:0] sel_t;
  logic               in_id;
  logic [NUM_TMR-1:0] tick_vec;

  logic [DATA_W-1:0]  tmr_rd   [NUM_TMR];
  logic [DATA_W-1:0]  tmr_lim  [NUM_TMR];
  logic [NUM_TMR-1:0] tmr_irq;
  logic [NUM_TMR-1:0] tmr_flag;
  logic [7:0]         id_b;
  logic [DATA_W-1:0]  rd_next;
  logic [DATA_W-1:0]  rdata_q;

  assign slot     = bus_addr[ADDR_W-1:WIN_LOG2];
  assign idx      = bus_addr[WIN_LOG2-1:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign in_id    = aligned && (slot == ID_SLOT);
  assign tick_vec = {tick_b, tick_a};

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    assign sel_t[i] = aligned && (slot == SLOT_W'(i));

    dt_timer #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .IDX_W(IDX_W)) u_tmr (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick_vec[i]),
      .wr_en  (bus_wr && sel_t[i]),
      .idx    (idx),
      .wdata  (bus_wdata),
      .rd_val (tmr_rd[i]),
      .irq_o  (tmr_irq[i]),
      .flag_o (tmr_flag[i]),
      .lim_o  (tmr_lim[i])
    );
  end

  dt_id_rom #(.IDX_W(IDX_W)) u_id (
    .idx    (idx),
    .byte_o (id_b)
  );

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (sel_t[i]) rd_next = tmr_rd[i];
    end
    if (in_id) rd_next = {{(DATA_W-8){1'b0}}, id_b};
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_next;
  end

  assign bus_rdata = rdata_q;
  assign irq       = |tmr_irq;

  assert_outside_write_inert_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !(|sel_t)) |=> ($stable(tmr_lim[0]) && $stable(tmr_lim[1])));

  assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !(|sel_t) && !in_id) |=> (bus_rdata == '0));

  assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  assert_irq_has_source_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> (tmr_flag[0] || tmr_flag[1]));
endmodule

// File: tb/tb_dual_timer.sv
module tb_dual_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_a = 1'b0, tick_b = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;
  logic rd_pend = 1'b0;

  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  dual_timer dut (
    .clk(clk), .rst(rst), .tick_a(tick_a), .tick_b(tick_b),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always @(posedge clk) rd_pend <= bus_rd;

  // Monitor: pops one expected item per completed read.
  always @(negedge clk) begin
    if (rd_pend) begin
      vectors++;
      if (q_exp.size() == 0) begin
        misses++;
        $display("FAIL scoreboard: read with no expectation, got %h expected none", bus_rdata);
      end else begin
        automatic logic [31:0] e = q_exp.pop_front();
        automatic string t = q_tag.pop_front();
        if (bus_rdata !== e) begin
          misses++;
          $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    bus_rd = 1'b1; bus_addr = a;
    q_exp.push_back(e); q_tag.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ticks(input logic a, input logic b, input int n);
    tick_a = a; tick_b = b;
    repeat (n) @(negedge clk);
    tick_a = 1'b0; tick_b = 1'b0;
  endtask

  task automatic chk(input logic [31:0] got, input logic [31:0] e, input string t);
    vectors++;
    if (got !== e) begin
      misses++;
      $display("FAIL %s: got %h expected %h", t, got, e);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: got running expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R5 reset state
    chk(bus_rdata, 32'h0, "R5 rdata after reset");
    chk({31'h0, irq}, 32'h0, "R5 irq after reset");
    rd(12'h000, 32'h2, "R5 ctrl A");
    rd(12'h00C, 32'hFFFF_FFFF, "R5 count A");
    rd(12'h004, 32'h0, "R5 limit A");
    rd(12'h020, 32'h2, "R5 ctrl B");
    rd(12'h030, 32'h0, "R5 raw flag B");
    @(negedge clk);
    chk(bus_rdata, 32'h0, "R4 rdata holds without read");

    // R2 identification bytes, back to back
    rd(12'hFE0, 32'h04, "R2 id0");
    rd(12'hFE4, 32'h18, "R2 id1");
    rd(12'hFE8, 32'h14, "R2 id2");
    rd(12'hFEC, 32'h00, "R2 id3");
    rd(12'hFF0, 32'h0D, "R2 id4");
    rd(12'hFF4, 32'hF0, "R2 id5");
    rd(12'hFF8, 32'h05, "R2 id6");
    rd(12'hFFC, 32'hB1, "R2 id7");
    wr(12'hFE0, 32'hFF);
    rd(12'hFE0, 32'h04, "R2 id write ignored");

    // R3 unmapped
    rd(12'hF00, 32'h0, "R3 0xF00");
    rd(12'hF04, 32'h0, "R3 0xF04");
    rd(12'h040, 32'h0, "R3 0x040");
    rd(12'h01C, 32'h0, "R3 spare slot");
    rd(12'h002, 32'h0, "R3 misaligned");
    wr(12'h044, 32'hDEAD);
    wr(12'hF00, 32'hBEEF);
    wr(12'h006, 32'h1111);
    rd(12'h004, 32'h0, "R3 limit A untouched");
    rd(12'h024, 32'h0, "R3 limit B untouched");

    // R1 routing, R6 loads
    wr(12'h004, 32'h1234);
    wr(12'h024, 32'h5678);
    rd(12'h004, 32'h1234, "R1 limit A");
    rd(12'h024, 32'h5678, "R1 limit B");
    rd(12'h00C, 32'h1234, "R1 count A");
    rd(12'h02C, 32'h5678, "R1 count B");
    wr(12'h00C, 32'h9999);
    rd(12'h00C, 32'h1234, "R6 count write ignored");

    // R7 counting, R11 independence
    wr(12'h000, 32'h07);
    ticks(1, 1, 5);
    rd(12'h00C, 32'h122F, "R7 A counted 5");
    rd(12'h02C, 32'h5678, "R7 B stopped ignores ticks");
    wr(12'h020, 32'h07);
    ticks(1, 0, 3);
    rd(12'h00C, 32'h122C, "R11 A on tick_a");
    rd(12'h02C, 32'h5678, "R11 B not on tick_a");
    ticks(0, 1, 2);
    rd(12'h00C, 32'h122C, "R11 A not on tick_b");
    rd(12'h02C, 32'h5676, "R11 B on tick_b");

    // R8 periodic, R9/R10 flags
    wr(12'h004, 32'h2);
    ticks(1, 0, 3);
    chk({31'h0, irq}, 32'h1, "R10 irq from A");
    rd(12'h00C, 32'h2, "R8 periodic reload");
    rd(12'h010, 32'h1, "R9 raw set");
    rd(12'h014, 32'h1, "R10 masked set");
    ticks(1, 0, 1);
    rd(12'h00C, 32'h1, "R8 after reload");
    wr(12'h008, 32'h5);
    rd(12'h00C, 32'h1, "R6 deferred keeps count");
    rd(12'h004, 32'h5, "R6 deferred sets limit");
    ticks(1, 0, 2);
    rd(12'h00C, 32'h5, "R6 deferred limit used");
    wr(12'h018, 32'h0);
    rd(12'h010, 32'h0, "R9 clear");
    chk({31'h0, irq}, 32'h0, "R10 irq low after clear");
    wr(12'h000, 32'h05);
    ticks(1, 0, 6);
    rd(12'h010, 32'h1, "R10 raw with ie off");
    rd(12'h014, 32'h0, "R10 masked with ie off");
    chk({31'h0, irq}, 32'h0, "R10 irq masked");

    // R9 clash: expiry and clear in one cycle
    wr(12'h018, 32'h0);
    ticks(1, 0, 5);
    rd(12'h010, 32'h0, "R9 flag clear before clash");
    tick_a = 1'b1; bus_wr = 1'b1; bus_addr = 12'h018; bus_wdata = 32'h0;
    @(negedge clk);
    tick_a = 1'b0; bus_wr = 1'b0;
    rd(12'h010, 32'h1, "R9 expiry wins over clear");
    rd(12'h00C, 32'h5, "R8 reload at clash");
    wr(12'h000, 32'h07);
    chk({31'h0, irq}, 32'h1, "R10 irq after ie set");
    wr(12'h018, 32'h0);
    rd(12'h010, 32'h0, "R9 clear alone");
    chk({31'h0, irq}, 32'h0, "R10 irq both low");
    wr(12'h024, 32'h1);
    ticks(0, 1, 2);
    chk({31'h0, irq}, 32'h1, "R10 irq from B alone");
    rd(12'h030, 32'h1, "R10 B raw");
    rd(12'h010, 32'h0, "R10 A raw still low");

    // R8 free-running and width
    wr(12'h000, 32'h03);
    wr(12'h004, 32'h0001_0003);
    rd(12'h00C, 32'h3, "R6 narrow load masked");
    rd(12'h004, 32'h0001_0003, "R6 limit full width");
    wr(12'h004, 32'h1);
    ticks(1, 0, 2);
    rd(12'h00C, 32'h0000_FFFF, "R8 free narrow wrap");
    wr(12'h000, 32'h13);
    wr(12'h004, 32'h0);
    ticks(1, 0, 1);
    rd(12'h00C, 32'hFFFF_FFFF, "R8 free wide wrap");

    // R8 one-shot
    wr(12'h018, 32'h0);
    wr(12'h000, 32'h0B);
    wr(12'h004, 32'h1);
    ticks(1, 0, 3);
    rd(12'h00C, 32'h0, "R8 oneshot stays zero");
    rd(12'h000, 32'h0A, "R8 oneshot run cleared");
    rd(12'h010, 32'h1, "R8 oneshot flag");

    // R7 prescale
    wr(12'h004, 32'd100);
    wr(12'h000, 32'h27);
    ticks(1, 0, 32);
    rd(12'h00C, 32'd98, "R7 prescale 16");
    wr(12'h000, 32'h47);
    ticks(1, 0, 255);
    rd(12'h00C, 32'd98, "R7 prescale 256 not yet");
    ticks(1, 0, 1);
    rd(12'h00C, 32'd97, "R7 prescale 256 step");

    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule